// File: doc/BRIEF.md
# Serial EEPROM configuration loader

This block fills a device's configuration state from a small byte image held in an external EEPROM. It runs when the asynchronous reset is released and when a synchronous soft reset is pulsed. Both of these also reload the strap registers from the strap input pins and clear the station address. The loader can also be started by a reload pulse, but only while it is idle. It fetches bytes one at a time through a request/response byte-read port, starting at address 0. The serial EEPROM protocol sits behind that port.

Byte 0 must hold the signature A5h, or the image is ignored. With a good signature, the loader reads bytes 1 to 11 as one sequential burst:
- Bytes 1 to 6 carry the station address.
- Byte 7 is a second signature. It decides whether bytes 8 to 11 replace the strap registers or are read and thrown away.

Every path ends the same way. For each of the three PHY ports, the loader issues three register writes whose data is derived from the current strap values. It then drops its busy output.

Top module: `cfg_image_loader`

## Requirements
- R1: After the asynchronous reset is released, or in the cycle after a soft-reset pulse, `busy` is high. The strap registers take the value of `strap_pins`, both address registers are zero, and a load starts from address 0. A soft reset takes effect even while busy.
- R2: A `reload` pulse while `busy` is low starts a load, and `busy` is high in the next cycle. A `reload` pulse while `busy` is high is ignored: the running load continues with unchanged addresses, and no second load follows.
- R3: `rd_req` is a single-cycle pulse. At most one request is outstanding at a time. The next request is issued only after `rd_valid`. Within one load, request addresses run 0, 1, 2 and upward without gaps.
- R4: If byte 0 is not 8'hA5, exactly one read is made. The address and strap registers keep their values, and PHY synchronization follows.
- R5: With a valid byte 0, bytes 1 to 4 are written to `mac_lo` least significant byte first (byte 1 in [7:0], byte 4 in [31:24]). Byte 5 goes to `mac_hi[7:0]` and byte 6 to `mac_hi[15:8]`.
- R6: If byte 7 equals 8'hA5, bytes 8 to 11 are written to `straps[7:0]`, `[15:8]`, `[23:16]` and `[31:24]` in that order.
- R7: If byte 7 is not 8'hA5, bytes 8 to 11 are still requested, for 12 reads in total, but `straps` keeps its previous value.
- R8: Each load ends with nine `phy_wr` pulses on consecutive cycles. Ports are taken in the order 0, 1, 2. For each port the register selects are taken in the order 0 (advertisement), 1 (special modes), 2 (basic control). The data is {reg[1:0], port[1:0], 4'h0, straps[8*port+:8]}, using the strap values that hold once all strap bytes of that load have been written.
- R9: `busy` is high while the loader runs and during every PHY write. It goes low in the cycle after the last PHY write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; a load starts after release |
| soft_rst | input | 1 | Synchronous soft reset pulse; restarts the loader |
| reload | input | 1 | Load request pulse, honoured only when idle |
| strap_pins | input | 32 | Strap pin values latched on reset |
| rd_req | output | 1 | Byte read request pulse |
| rd_addr | output | 8 | Byte address of the request |
| rd_valid | input | 1 | Single-cycle read response strobe |
| rd_data | input | 8 | Read response byte |
| mac_lo | output | 32 | Station address, low word |
| mac_hi | output | 16 | Station address, high half-word |
| straps | output | 32 | Configuration strap registers |
| phy_wr | output | 1 | PHY register write strobe |
| phy_port | output | 2 | PHY port index of the write |
| phy_reg | output | 2 | Register select of the write (0 adv, 1 special, 2 basic) |
| phy_data | output | 16 | PHY write data |
| busy | output | 1 | Loader running |

## Verification
The bench targets these corner cases:
- Near-miss signature (A4h) in byte 0. A loader that continues past it would make twelve reads and overwrite the address registers.
- Bad strap flag. A design that stops reading early would lose the burst length of twelve; one that applies the bytes anyway would change `straps`, and the PHY write data would give it away.
- Reload pulse in the middle of a load. A loader that restarts or queues the request shows an address sequence that jumps back to 0, or extra reads.
- Soft reset during a burst. It must clear the address registers, restore the pin straps and start again from address 0.

The PHY write scoreboard also catches a wrong port or register order, and writes that use the strap values from before the update.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int IMG_LAST  = 11;
  localparam int LO_FIRST  = 1;
  localparam int LO_BYTES  = 4;
  localparam int HI_FIRST  = LO_FIRST + LO_BYTES;
  localparam int HI_BYTES  = 2;
  localparam int FLAG_IDX  = HI_FIRST + HI_BYTES;
  localparam int ST_FIRST  = FLAG_IDX + 1;
  localparam int ST_BYTES  = IMG_LAST - FLAG_IDX;
  localparam int NSEL      = 3;
  localparam logic [BYTE_W-1:0] SIG = 8'hA5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH,
    ST_REQ,
    ST_WAIT,
    ST_PHY
  } ld_state_t;

  // Derived PHY default for one register of one port.
  function automatic logic [15:0] phy_default(input logic [1:0] sel,
                                              input logic [1:0] port,
                                              input logic [7:0] strap_byte);
    return {sel, port, 4'h0, strap_byte};
  endfunction
endpackage

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              reload,
  input  logic              rd_valid,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              phy_done,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              byte_ev,
  output logic [ADDR_W-1:0] byte_idx,
  output logic [BYTE_W-1:0] byte_val,
  output logic              strap_ok,
  output logic              latch_pins,
  output logic              phy_start,
  output logic              busy
);
  ld_state_t         state_q;
  logic [ADDR_W-1:0] idx_q;
  logic              strap_ok_q;
  logic              sig_bad;
  logic              img_end;

  always_comb begin
    rd_req     = (state_q == ST_REQ);
    rd_addr    = idx_q;
    byte_ev    = (state_q == ST_WAIT) && rd_valid;
    byte_idx   = idx_q;
    byte_val   = rd_data;
    sig_bad    = byte_ev && (idx_q == '0) && (rd_data != SIG);
    img_end    = byte_ev && (idx_q == ADDR_W'(IMG_LAST));
    phy_start  = sig_bad || img_end;
    latch_pins = (state_q == ST_LATCH);
    busy       = (state_q != ST_IDLE);
    strap_ok   = strap_ok_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_LATCH;
      idx_q      <= '0;
      strap_ok_q <= 1'b0;
    end else if (soft_rst) begin
      state_q    <= ST_LATCH;
      idx_q      <= '0;
      strap_ok_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (reload) begin
          state_q    <= ST_REQ;
          idx_q      <= '0;
          strap_ok_q <= 1'b0;
        end
        ST_LATCH: begin
          state_q <= ST_REQ;
          idx_q   <= '0;
        end
        ST_REQ: state_q <= ST_WAIT;
        ST_WAIT: if (byte_ev) begin
          if (idx_q == ADDR_W'(FLAG_IDX)) strap_ok_q <= (rd_data == SIG);
          if (phy_start) state_q <= ST_PHY;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_REQ;
          end
        end
        ST_PHY: if (phy_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R3
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr <= ADDR_W'(IMG_LAST)); // R3
  AST_RELOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && reload && !rd_valid && !soft_rst) |=> $stable(idx_q)); // R2
  AST_SOFT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (state_q == ST_LATCH && busy)); // R1
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(phy_done)); // R9
endmodule

// File: rtl/cfgld_store.sv
module cfgld_store
  import cfgld_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       latch_pins,
  input  logic [ST_BYTES*BYTE_W-1:0] strap_pins,
  input  logic                       byte_ev,
  input  logic [ADDR_W-1:0]          byte_idx,
  input  logic [BYTE_W-1:0]          byte_val,
  input  logic                       strap_ok,
  output logic [LO_BYTES*BYTE_W-1:0] mac_lo,
  output logic [HI_BYTES*BYTE_W-1:0] mac_hi,
  output logic [ST_BYTES*BYTE_W-1:0] straps
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_lo <= '0;
      mac_hi <= '0;
      straps <= '0;
    end else if (latch_pins) begin
      mac_lo <= '0;
      mac_hi <= '0;
      straps <= strap_pins;
    end else if (byte_ev) begin
      for (int k = 0; k < LO_BYTES; k++)
        if (byte_idx == ADDR_W'(LO_FIRST + k)) mac_lo[k*BYTE_W +: BYTE_W] <= byte_val;
      for (int k = 0; k < HI_BYTES; k++)
        if (byte_idx == ADDR_W'(HI_FIRST + k)) mac_hi[k*BYTE_W +: BYTE_W] <= byte_val;
      for (int k = 0; k < ST_BYTES; k++)
        if (strap_ok && byte_idx == ADDR_W'(ST_FIRST + k)) straps[k*BYTE_W +: BYTE_W] <= byte_val;
    end
  end

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ev && !strap_ok && !latch_pins) |=> $stable(straps)); // R7
  AST_FLAG_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ev && byte_idx == '0) |=> ($stable(mac_lo) && $stable(mac_hi) && $stable(straps))); // R4
endmodule

// File: rtl/cfgld_phy_sync.sv
module cfgld_phy_sync
  import cfgld_pkg::*;
#(
  parameter int NPORT = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       abort,
  input  logic [ST_BYTES*BYTE_W-1:0] straps,
  output logic                       phy_wr,
  output logic [$clog2(NPORT)-1:0]   phy_port,
  output logic [1:0]                 phy_reg,
  output logic [15:0]                phy_data,
  output logic                       done
);
  localparam int PORT_W = $clog2(NPORT);

  logic              active_q;
  logic [PORT_W-1:0] port_q;
  logic [1:0]        sel_q;
  logic              last_sel;
  logic              last;

  always_comb begin
    last_sel = (sel_q == 2'(NSEL - 1));
    last     = last_sel && (port_q == PORT_W'(NPORT - 1));
    done     = active_q && last;
    phy_wr   = active_q;
    phy_port = port_q;
    phy_reg  = sel_q;
    phy_data = phy_default(sel_q, 2'(port_q), straps[{port_q, 3'b000} +: BYTE_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      port_q   <= '0;
      sel_q    <= '0;
    end else if (abort) begin
      active_q <= 1'b0;
      port_q   <= '0;
      sel_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      port_q   <= '0;
      sel_q    <= '0;
    end else if (active_q) begin
      if (last) begin
        active_q <= 1'b0;
        port_q   <= '0;
        sel_q    <= '0;
      end else if (last_sel) begin
        sel_q  <= '0;
        port_q <= port_q + 1'b1;
      end else begin
        sel_q <= sel_q + 1'b1;
      end
    end
  end

  AST_PORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr |-> (phy_port <= PORT_W'(NPORT - 1) && phy_reg <= 2'(NSEL - 1))); // R8
  AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_wr && phy_reg != 2'd0) |-> ($past(phy_wr) && $past(phy_reg) == phy_reg - 2'd1
                                     && $past(phy_port) == phy_port)); // R8
  AST_PORT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_wr && phy_reg == 2'd0 && phy_port != '0) |-> ($past(phy_wr)
      && $past(phy_reg) == 2'(NSEL - 1) && $past(phy_port) == phy_port - 1'b1)); // R8
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cfgld_pkg::*;
#(
  parameter int NPORT = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       soft_rst,
  input  logic                       reload,
  input  logic [ST_BYTES*BYTE_W-1:0] strap_pins,
  output logic                       rd_req,
  output logic [ADDR_W-1:0]          rd_addr,
  input  logic                       rd_valid,
  input  logic [BYTE_W-1:0]          rd_data,
  output logic [LO_BYTES*BYTE_W-1:0] mac_lo,
  output logic [HI_BYTES*BYTE_W-1:0] mac_hi,
  output logic [ST_BYTES*BYTE_W-1:0] straps,
  output logic                       phy_wr,
  output logic [$clog2(NPORT)-1:0]   phy_port,
  output logic [1:0]                 phy_reg,
  output logic [15:0]                phy_data,
  output logic                       busy
);
  logic              byte_ev;
  logic [ADDR_W-1:0] byte_idx;
  logic [BYTE_W-1:0] byte_val;
  logic              strap_ok;
  logic              latch_pins;
  logic              phy_start;
  logic              phy_done;

  cfgld_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .reload     (reload),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .phy_done   (phy_done),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .byte_ev    (byte_ev),
    .byte_idx   (byte_idx),
    .byte_val   (byte_val),
    .strap_ok   (strap_ok),
    .latch_pins (latch_pins),
    .phy_start  (phy_start),
    .busy       (busy)
  );

  cfgld_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_pins (latch_pins),
    .strap_pins (strap_pins),
    .byte_ev    (byte_ev),
    .byte_idx   (byte_idx),
    .byte_val   (byte_val),
    .strap_ok   (strap_ok),
    .mac_lo     (mac_lo),
    .mac_hi     (mac_hi),
    .straps     (straps)
  );

  cfgld_phy_sync #(.NPORT(NPORT)) u_phy (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (phy_start),
    .abort    (soft_rst),
    .straps   (straps),
    .phy_wr   (phy_wr),
    .phy_port (phy_port),
    .phy_reg  (phy_reg),
    .phy_data (phy_data),
    .done     (phy_done)
  );

  AST_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr |-> busy); // R9
endmodule

// File: tb/cfg_image_loader_tb.sv
module cfg_image_loader_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, soft_rst, reload;
  logic [31:0] strap_pins;
  logic        rd_req;
  logic [7:0]  rd_addr;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [31:0] mac_lo;
  logic [15:0] mac_hi;
  logic [31:0] straps;
  logic        phy_wr;
  logic [1:0]  phy_port, phy_reg;
  logic [15:0] phy_data;
  logic        busy;

  cfg_image_loader u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reload(reload),
    .strap_pins(strap_pins), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .mac_lo(mac_lo), .mac_hi(mac_hi),
    .straps(straps), .phy_wr(phy_wr), .phy_port(phy_port), .phy_reg(phy_reg),
    .phy_data(phy_data), .busy(busy)
  );

  // EEPROM byte model with programmable latency
  logic [7:0] img [0:15];
  int         lat = 1;
  int         cnt;
  logic [7:0] req_a;

  always @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      cnt      <= 0;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= 1'b0;
      if (cnt == 1) begin
        rd_valid <= 1'b1;
        rd_data  <= img[req_a[3:0]];
      end
      if (cnt != 0) cnt <= cnt - 1;
      if (rd_req) begin
        cnt   <= lat;
        req_a <= rd_addr;
      end
    end
  end

  // Scoreboard of expected PHY writes: {port, reg, data}
  logic [19:0] expq [$];
  int rd_total  = 0;
  int run_base  = 0;
  int mon_checks = 0;
  int mon_fails  = 0;
  logic prev_wr = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_req) begin
        mon_checks++;
        if (rd_addr != 8'(rd_total - run_base)) begin
          mon_fails++;
          $display("FAIL R3 read address: actual %0d expected %0d", rd_addr, rd_total - run_base);
        end
        rd_total++;
      end
      if (phy_wr) begin
        mon_checks++;
        if (expq.size() == 0) begin
          mon_fails++;
          $display("FAIL R8 unexpected phy write: actual %h expected none", {phy_port, phy_reg, phy_data});
        end else begin
          logic [19:0] e;
          e = expq.pop_front();
          if ({phy_port, phy_reg, phy_data} != e) begin
            mon_fails++;
            $display("FAIL R8 phy write: actual %h expected %h", {phy_port, phy_reg, phy_data}, e);
          end
        end
      end
      if (prev_wr && !phy_wr) begin
        mon_checks++;
        if (busy) begin
          mon_fails++;
          $display("FAIL R9 busy after last phy write: actual 1 expected 0");
        end
      end
      prev_wr = phy_wr;
    end
  end

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_phy(input logic [31:0] st);
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 3; s++)
        expq.push_back({p[1:0], s[1:0], s[1:0], p[1:0], 4'h0, st[8*p +: 8]});
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (busy && t < 2000) begin
      tick();
      t++;
    end
    chk(!busy, {tag, " loader finished"}, busy, 0);
  endtask

  task automatic set_img(input logic [7:0] b0, input logic [47:0] mac,
                         input logic [7:0] b7, input logic [31:0] st);
    img[0] = b0;
    for (int k = 0; k < 6; k++) img[1+k] = mac[8*k +: 8];
    img[7] = b7;
    for (int k = 0; k < 4; k++) img[8+k] = st[8*k +: 8];
  endtask

  task automatic start_reload(input logic [31:0] exp_st);
    run_base = rd_total;
    push_phy(exp_st);
    reload = 1'b1;
    tick();
    reload = 1'b0;
    chk(busy, "R2 busy after idle reload", busy, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks + mon_checks, n_fails + mon_fails);
      $finish;
    end
  endtask

  initial begin
    #(10 * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; reload = 1'b0;
    strap_pins = 32'h1357_9BDF;
    for (int k = 0; k < 16; k++) img[k] = 8'h00;
    push_phy(32'h1357_9BDF);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset release starts a load with pin straps
    chk(busy, "R1 busy after reset release", busy, 1);
    wait_idle("R1");
    chk(rd_total - run_base == 1, "R4 single read on bad signature", rd_total - run_base, 1);
    chk(mac_lo == 0 && mac_hi == 0, "R1 address cleared", {mac_hi, mac_lo}, 0);
    chk(straps == strap_pins, "R1 straps from pins", straps, strap_pins);
    chk(expq.size() == 0, "R8 all phy writes seen", expq.size(), 0);

    // R5 R6: full valid image
    lat = 2;
    set_img(8'hA5, 48'h6655_4433_2211, 8'hA5, 32'hC4C3_C2C1);
    start_reload(32'hC4C3_C2C1);
    wait_idle("R6");
    chk(rd_total - run_base == 12, "R3 twelve reads", rd_total - run_base, 12);
    chk(mac_lo == 32'h4433_2211, "R5 low address order", mac_lo, 32'h4433_2211);
    chk(mac_hi == 16'h6655, "R5 high address order", mac_hi, 16'h6655);
    chk(straps == 32'hC4C3_C2C1, "R6 straps loaded", straps, 32'hC4C3_C2C1);
    chk(expq.size() == 0, "R8 phy writes with new straps", expq.size(), 0);

    // R7: strap flag bad, bytes read but discarded
    lat = 3;
    set_img(8'hA5, 48'hA6A5_A4A3_A2A1, 8'h5A, 32'h0F0E_0D0C);
    start_reload(32'hC4C3_C2C1);
    wait_idle("R7");
    chk(rd_total - run_base == 12, "R7 burst kept at twelve reads", rd_total - run_base, 12);
    chk(straps == 32'hC4C3_C2C1, "R7 straps unchanged", straps, 32'hC4C3_C2C1);
    chk(mac_lo == 32'hA4A3_A2A1 && mac_hi == 16'hA6A5, "R5 address still loaded",
        {mac_hi, mac_lo}, 48'hA6A5_A4A3_A2A1);
    chk(expq.size() == 0, "R8 phy writes with old straps", expq.size(), 0);

    // R4: near-miss signature
    lat = 1;
    set_img(8'hA4, 48'h1111_1111_1111, 8'hA5, 32'h2222_2222);
    start_reload(32'hC4C3_C2C1);
    wait_idle("R4");
    chk(rd_total - run_base == 1, "R4 one read only", rd_total - run_base, 1);
    chk(mac_lo == 32'hA4A3_A2A1 && mac_hi == 16'hA6A5, "R4 address untouched",
        {mac_hi, mac_lo}, 48'hA6A5_A4A3_A2A1);
    chk(straps == 32'hC4C3_C2C1, "R4 straps untouched", straps, 32'hC4C3_C2C1);

    // R2: reload while busy is ignored
    lat = 2;
    set_img(8'hA5, 48'h0605_0403_0201, 8'hA5, 32'hD4D3_D2D1);
    start_reload(32'hD4D3_D2D1);
    repeat (6) tick();
    reload = 1'b1;
    tick();
    reload = 1'b0;
    wait_idle("R2");
    repeat (3) tick();
    chk(!busy, "R2 no second load after busy reload", busy, 0);
    chk(rd_total - run_base == 12, "R2 read count unchanged", rd_total - run_base, 12);
    chk(expq.size() == 0, "R2 one phy sequence", expq.size(), 0);
    chk(straps == 32'hD4D3_D2D1, "R6 straps loaded again", straps, 32'hD4D3_D2D1);

    // R1: soft reset during a burst
    set_img(8'hA5, 48'hEEEE_EEEE_EEEE, 8'hA5, 32'hE4E3_E2E1);
    start_reload(32'hE4E3_E2E1);
    repeat (8) tick();
    soft_rst = 1'b1;
    img[0] = 8'h00;
    tick();
    soft_rst = 1'b0;
    chk(busy, "R1 busy after soft reset", busy, 1);
    expq.delete();
    push_phy(32'h1357_9BDF);
    run_base = rd_total;
    wait_idle("R1 soft");
    chk(rd_total - run_base == 1, "R1 restart from address 0", rd_total - run_base, 1);
    chk(mac_lo == 0 && mac_hi == 0, "R1 address cleared by soft reset", {mac_hi, mac_lo}, 0);
    chk(straps == strap_pins, "R1 straps from pins after soft reset", straps, strap_pins);
    chk(expq.size() == 0, "R8 phy writes after soft reset", expq.size(), 0);

    repeat (3) tick();
    finish_run();
  end
endmodule